// File: doc/BRIEF.md
# Serial Attenuation Control Register

This block is the digital control front end of a 6-bit step attenuator. A host writes an 8-bit frame over a four-wire serial port. The port has a serial clock, a data input, an active-low select and an active-low serial reset. The frame enters a shift register. When select goes high again, the six control bits in the frame are copied into a holding register. That register drives the attenuator section controls. The two remaining frame bits are reserved. They travel through the shift path but do not change the attenuation.

The control code is inverted. A 1 in a control bit takes that section out of the RF path, and a 0 puts it in. An all-zero code therefore gives the full 31.5 dB in 0.5 dB steps. System reset leaves the block at this maximum setting, and so does a falling edge on the serial reset.

The serial data output shows each frame bit eight serial clock edges after it entered. Several devices can share one select line by feeding the output of one device into the data input of the next. All serial pins are assumed to be synchronous to `clk` already. An edge on a pin takes effect at the first `clk` edge that samples the new level.

Top module: `sda_serial_ctrl`

## Requirements
- R1: Each rising edge of the serial clock seen while select is low shifts one bit in, least significant bit first. After eight such edges, the first bit sent sits at frame bit 0, and bits 0 to 5 are control bits D0 to D5.
- R2: While select is high, serial clock edges are ignored and the shift register keeps its content.
- R3: On a rising edge of select, frame bits 5:0 are copied to `att_code` at that same `clk` edge. Frame bits 7:6 are reserved and never reach `att_code`.
- R4: `att_half_db` equals 63 minus `att_code`, in units of 0.5 dB. An all-zero code reads 63 (31.5 dB) and an all-ones code reads 0.
- R5: A falling edge on `ser_rst_n` clears both the shift register and `att_code` to zero. A select pulse that follows at once keeps maximum attenuation.
- R6: While `rst` is high at a `clk` edge, `att_code` becomes 0 and the shift register becomes 0, so `ser_dout` is 0.
- R7: `ser_dout` shows the bit that was shifted in eight accepted serial clock edges earlier, reserved bits included. This lets the frame that follows push the previous frame out to the next device in the chain.
- R8: `att_code` changes only on a select rising edge, a serial reset falling edge, or `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock, acted on at its rising edge |
| ser_din | input | 1 | Serial data input, least significant bit first |
| ser_sel_n | input | 1 | Active-low select. Its rising edge loads the control code |
| ser_rst_n | input | 1 | Active-low serial reset. Its falling edge forces maximum attenuation |
| ser_dout | output | 1 | Serial data delayed by eight shifts, for chaining |
| att_code | output | 6 | Active control code driving the attenuator sections (0 = section inserted) |
| att_half_db | output | 6 | Decoded attenuation in 0.5 dB units |

## Verification
Six frames are loaded back to back. Their patterns are all-ones control, a single low bit, a single high bit at the top, reserved bits set over a zero code, and two alternating patterns. Each loaded code and its decoded value are compared, which separates bit-order mistakes from inversion mistakes. Because the frames follow one another without a reset, the data output is checked bit by bit against the previous frame, and this shows the eight-shift delay and the pass-through of the reserved bits. Directed cases then clock a frame in while select is high, pulse the serial reset before a select pulse, and apply system reset over a loaded code.

// File: rtl/sda_pkg.sv
package sda_pkg;

    localparam int CTRL_W  = 6;
    localparam int RSV_W   = 2;
    localparam int FRAME_W = CTRL_W + RSV_W;

    typedef logic [CTRL_W-1:0] ctrl_t;

    // Frame as it sits in the shift register once fully loaded
    typedef struct packed {
        logic [RSV_W-1:0] rsv;
        ctrl_t            ctrl;
    } frame_t;

    // Sampled serial pin levels
    typedef struct packed {
        logic sclk;
        logic sel_n;
        logic srst_n;
    } pins_t;

    // Events decoded from pin transitions
    typedef struct packed {
        logic shift;
        logic load;
        logic clear;
    } evt_t;

    // Levels the pins rest at when idle
    localparam pins_t PINS_IDLE = '{sclk: 1'b0, sel_n: 1'b1, srst_n: 1'b1};

    // All sections inserted
    localparam ctrl_t CTRL_MAX_ATTEN = '0;

    // A set bit removes a section, so the inserted amount is the complement
    function automatic ctrl_t half_db_of(ctrl_t code);
        return ~code;
    endfunction

endpackage

// File: rtl/sda_event_detect.sv
module sda_event_detect
    import sda_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins,
    output evt_t  evt
);

    pins_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PINS_IDLE;
        else     prev_q <= pins;
    end

    always_comb begin
        evt.clear = prev_q.srst_n & ~pins.srst_n;
        evt.load  = ~prev_q.sel_n & pins.sel_n;
        // clock is gated off while select is high
        evt.shift = ~prev_q.sclk & pins.sclk & ~pins.sel_n;
    end

endmodule

// File: rtl/sda_shift_chain.sv
module sda_shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic             clear,
    input  logic             din,
    output logic [WIDTH-1:0] q,
    output logic             dout
);

    always_ff @(posedge clk) begin
        if (rst || clear) q <= '0;
        else if (shift)   q <= {din, q[WIDTH-1:1]};
    end

    assign dout = q[0];

endmodule

// File: rtl/sda_hold_reg.sv
module sda_hold_reg
    import sda_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   clear,
    input  frame_t frame,
    output ctrl_t  code
);

    always_ff @(posedge clk) begin
        if (rst || clear) code <= CTRL_MAX_ATTEN;
        else if (load)    code <= frame.ctrl;
    end

endmodule

// File: rtl/sda_serial_ctrl.sv
module sda_serial_ctrl
    import sda_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_sel_n,
    input  logic              ser_rst_n,
    output logic              ser_dout,
    output logic [CTRL_W-1:0] att_code,
    output logic [CTRL_W-1:0] att_half_db
);

    pins_t              pins;
    evt_t               evt;
    logic               evt_shift;
    logic               evt_load;
    logic               evt_clear;
    logic [FRAME_W-1:0] frame_q;
    ctrl_t              code_q;

    assign pins = '{sclk: ser_clk, sel_n: ser_sel_n, srst_n: ser_rst_n};

    sda_event_detect u_evt (
        .clk  (clk),
        .rst  (rst),
        .pins (pins),
        .evt  (evt)
    );

    assign evt_shift = evt.shift;
    assign evt_load  = evt.load;
    assign evt_clear = evt.clear;

    sda_shift_chain #(.WIDTH(FRAME_W)) u_chain (
        .clk   (clk),
        .rst   (rst),
        .shift (evt_shift),
        .clear (evt_clear),
        .din   (ser_din),
        .q     (frame_q),
        .dout  (ser_dout)
    );

    sda_hold_reg u_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (evt_load),
        .clear (evt_clear),
        .frame (frame_t'(frame_q)),
        .code  (code_q)
    );

    assign att_code    = code_q;
    assign att_half_db = half_db_of(code_q);

endmodule

// File: rtl/sda_serial_ctrl_chk.sv
module sda_serial_ctrl_chk
    import sda_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ser_din,
    input logic               ser_dout,
    input logic               ser_sel_n,
    input logic               evt_shift,
    input logic               evt_load,
    input logic               evt_clear,
    input logic [FRAME_W-1:0] frame_q,
    input logic [CTRL_W-1:0]  att_code,
    input logic [CTRL_W-1:0]  att_half_db
);

    AST_SHIFT_IN_TOP: assert property (@(posedge clk) disable iff (rst)
        evt_shift && !evt_clear |=> frame_q[FRAME_W-1] == $past(ser_din)); // R1

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
        ser_sel_n && !evt_clear |=> $stable(frame_q)); // R2

    AST_LOAD_COPY: assert property (@(posedge clk) disable iff (rst)
        evt_load && !evt_clear |=> att_code == $past(frame_q[CTRL_W-1:0])); // R3

    AST_DECODE_SUM: assert property (@(posedge clk) disable iff (rst)
        att_half_db == CTRL_W'((1 << CTRL_W) - 1 - int'(att_code))); // R4

    AST_CLEAR_MAX: assert property (@(posedge clk) disable iff (rst)
        evt_clear |=> att_code == '0 && frame_q == '0); // R5

    AST_DOUT_NEXT: assert property (@(posedge clk) disable iff (rst)
        evt_shift && !evt_clear |=> ser_dout == $past(frame_q[1])); // R7

    AST_CODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !evt_load && !evt_clear |=> $stable(att_code)); // R8

endmodule

bind sda_serial_ctrl sda_serial_ctrl_chk u_chk (.*);

// File: tb/sda_serial_ctrl_tb.sv
module sda_serial_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_din = 1'b0;
    logic       ser_sel_n = 1'b1;
    logic       ser_rst_n = 1'b1;
    logic       ser_dout;
    logic [5:0] att_code;
    logic [5:0] att_half_db;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    sda_serial_ctrl u_dut (
        .clk         (clk),
        .rst         (rst),
        .ser_clk     (ser_clk),
        .ser_din     (ser_din),
        .ser_sel_n   (ser_sel_n),
        .ser_rst_n   (ser_rst_n),
        .ser_dout    (ser_dout),
        .att_code    (att_code),
        .att_half_db (att_half_db)
    );

    // {frame, expected half-dB}; expected code is frame[5:0]
    localparam logic [13:0] VEC [6] = '{
        {8'h3F, 6'd0},
        {8'h01, 6'd62},
        {8'h20, 6'd31},
        {8'hC0, 6'd63},
        {8'h95, 6'd42},
        {8'h6A, 6'd21}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // one serial bit: raise then lower the serial clock, one clk each
    task automatic send_bit(input logic b);
        ser_din = b;
        ser_clk = 1'b1;
        tick();
        ser_clk = 1'b0;
        tick();
    endtask

    task automatic sel_low();
        ser_sel_n = 1'b0;
        tick();
    endtask

    task automatic sel_high();
        ser_sel_n = 1'b1;
        tick();
    endtask

    initial begin
        logic [7:0] prev;
        prev = 8'h00;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R6: reset state
        check("R6 reset code", int'(att_code), 0);
        check("R6 reset half_db", int'(att_half_db), 63);
        check("R6 reset dout", int'(ser_dout), 0);

        // Table walk, frames back to back so dout carries the previous frame
        for (int k = 0; k < 6; k++) begin
            logic [7:0] w;
            w = VEC[k][13:6];
            sel_low();
            for (int i = 0; i < 8; i++) begin
                check("R7 chain dout", int'(ser_dout), int'(prev[i]));
                send_bit(w[i]);
            end
            sel_high();
            check("R1/R3 loaded code", int'(att_code), int'(w[5:0]));
            check("R4 half_db", int'(att_half_db), int'(VEC[k][5:0]));
            prev = w;
        end
        // R3: frame C0 loaded with reserved bits set gave code 0 above

        // R2: clocks with select high are ignored
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        check("R8 code after gated clocks", int'(att_code), 8'h2A);
        sel_low();
        sel_high();
        check("R2 gated frame kept", int'(att_code), 8'h2A);
        check("R2 gated dout", int'(ser_dout), int'(prev[0]));

        // R5: serial reset then select pulse
        ser_rst_n = 1'b0;
        tick();
        check("R5 clear code", int'(att_code), 0);
        check("R5 clear half_db", int'(att_half_db), 63);
        check("R5 clear dout", int'(ser_dout), 0);
        ser_rst_n = 1'b1;
        tick();
        sel_low();
        sel_high();
        check("R5 code after select", int'(att_code), 0);

        // R6: system reset over a loaded code
        sel_low();
        for (int i = 0; i < 8; i++) send_bit(1'b1);
        sel_high();
        check("R3 all ones", int'(att_code), 63);
        check("R4 minimum", int'(att_half_db), 0);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R6 code after rst", int'(att_code), 0);
        check("R6 dout after rst", int'(ser_dout), 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule